// File: doc/BRIEF.md
# Gamepad Poll Response Formatter

This block turns the live state of a gamepad into a four-byte status word and replies to commands from a command processor. Fourteen button levels and two signed 8-bit stick axes come in every cycle. A single command byte is offered with a valid/ready handshake. The block accepts it only when idle and then returns that command's fixed reply, one byte per beat, on a valid/ready response stream that marks the final byte.

The status word goes through two fix-ups before it is captured. Each stick axis is limited to the symmetric range -86..+86. A reset chord (L, R and Start held together) raises a flag bit, clears the Start bit and zeroes both axes. The word is captured once, at the cycle the command is accepted, and every byte of the reply comes from that capture. Live inputs can therefore change freely while a reply is being sent.

Top module: `pad_poll_responder`

## Requirements
- R1: Input map of `btn_i`: bit0 D-right, bit1 D-left, bit2 D-down, bit3 D-up, bit4 Start, bit5 Z, bit6 B, bit7 A, bit8 C-right, bit9 C-left, bit10 C-down, bit11 C-up, bit12 R, bit13 L. The first status byte is, from MSB to LSB: A, B, Z, Start, D-up, D-down, D-left, D-right.
- R2: The second status byte is, from MSB to LSB: chord flag, constant 0, L, R, C-up, C-down, C-left, C-right.
- R3: When L, R and Start are all 1, the chord flag is 1, the Start bit of byte one is 0, and both axis bytes are 0x00.
- R4: The third and fourth status bytes are the X and Y axes, read as two's complement and limited to -86..+86 (0xAA..0x56). Values already in range pass through unchanged.
- R5: Command 0x01 returns four bytes in the order byte one, byte two, X, Y.
- R6: Command 0x00 returns three bytes: 0x05, 0x00, 0x01.
- R7: Commands 0x02 and 0x03 each return one byte of 0x00.
- R8: Any command above 0x03 returns no bytes. `err_o` is 1 for exactly the cycle after acceptance, and `cmd_ready_o` stays 1.
- R9: The reply uses the status word as it was in the cycle the command was accepted, whatever the inputs do afterwards.
- R10: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, `rsp_byte_o` and `rsp_last_o` hold their values. `rsp_last_o` is 1 only on the final byte of a reply.
- R11: After reset, `cmd_ready_o` is 1 and `rsp_valid_o` and `err_o` are 0. `cmd_ready_o` is 0 from the cycle after a known command is accepted until the cycle after its last byte is taken. Commands offered in that window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 14 | Button levels, mapped as in R1 |
| axis_x_i | input | 8 | Signed X stick value |
| axis_y_i | input | 8 | Signed Y stick value |
| cmd_valid_i | input | 1 | A command byte is offered |
| cmd_byte_i | input | 8 | Command code |
| cmd_ready_o | output | 1 | Block is idle and takes a command |
| rsp_valid_o | output | 1 | A reply byte is presented |
| rsp_byte_o | output | 8 | Reply byte |
| rsp_last_o | output | 1 | Presented byte is the last of the reply |
| rsp_ready_i | input | 1 | Consumer takes the reply byte |
| err_o | output | 1 | One-cycle flag for an unknown command |

## Verification
The bench targets the limit boundaries at ±86, ±87 and the extremes 0x7F and 0x80. A clamp built with unsigned compares or an off-by-one limit would pass 0x80 through or cut 86 down to 85. It drives the chord with and without Start, so a flag built from L and R alone, or a chord that clears Start but leaves the axes, shows up as a wrong second or third byte. It also changes every input while a stalled reply is pending, and offers commands while busy. Sampling the live word per byte would then return mixed data, and a decoder that takes commands while busy would drop or restart replies. Unknown codes check that the error pulse lasts one cycle and that no reply beat appears.

// File: rtl/pad_poll_pkg.sv
package pad_poll_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int BTN_N      = 14;

  // button input positions
  localparam int BI_DRIGHT = 0;
  localparam int BI_DLEFT  = 1;
  localparam int BI_DDOWN  = 2;
  localparam int BI_DUP    = 3;
  localparam int BI_START  = 4;
  localparam int BI_Z      = 5;
  localparam int BI_B      = 6;
  localparam int BI_A      = 7;
  localparam int BI_CRIGHT = 8;
  localparam int BI_CLEFT  = 9;
  localparam int BI_CDOWN  = 10;
  localparam int BI_CUP    = 11;
  localparam int BI_R      = 12;
  localparam int BI_L      = 13;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t main_btn;
    byte_t aux_btn;
    byte_t axis_x;
    byte_t axis_y;
  } pad_word_t;

  localparam byte_t CMD_IDENT = 8'h00;
  localparam byte_t CMD_POLL  = 8'h01;
  localparam byte_t CMD_AUX_A = 8'h02;
  localparam byte_t CMD_AUX_B = 8'h03;
endpackage

// File: rtl/pad_axis_clamp.sv
module pad_axis_clamp
  import pad_poll_pkg::*;
#(
  parameter int LIMIT = 86
) (
  input  logic signed [BYTE_W-1:0] raw_i,
  input  logic                     zero_i,
  output logic        [BYTE_W-1:0] clamped_o
);
  localparam logic signed [BYTE_W-1:0] HI = BYTE_W'(LIMIT);
  localparam logic signed [BYTE_W-1:0] LO = -HI;

  always_comb begin
    if (zero_i)          clamped_o = '0;
    else if (raw_i > HI) clamped_o = HI;
    else if (raw_i < LO) clamped_o = LO;
    else                 clamped_o = raw_i;
  end
endmodule

// File: rtl/pad_status_pack.sv
module pad_status_pack
  import pad_poll_pkg::*;
#(
  parameter int AXIS_LIMIT = 86
) (
  input  logic [BTN_N-1:0]  btn_i,
  input  logic [BYTE_W-1:0] axis_x_i,
  input  logic [BYTE_W-1:0] axis_y_i,
  output pad_word_t         word_o
);
  localparam int N_AXES = 2;

  logic                     chord;
  logic signed [BYTE_W-1:0] raw [N_AXES];
  logic        [BYTE_W-1:0] lim [N_AXES];

  assign chord  = btn_i[BI_L] & btn_i[BI_R] & btn_i[BI_START];
  assign raw[0] = axis_x_i;
  assign raw[1] = axis_y_i;

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    pad_axis_clamp #(.LIMIT(AXIS_LIMIT)) u_clamp (
      .raw_i    (raw[g]),
      .zero_i   (chord),
      .clamped_o(lim[g])
    );
  end

  always_comb begin
    word_o.main_btn = {btn_i[BI_A], btn_i[BI_B], btn_i[BI_Z],
                       btn_i[BI_START] & ~chord,
                       btn_i[BI_DUP], btn_i[BI_DDOWN],
                       btn_i[BI_DLEFT], btn_i[BI_DRIGHT]};
    word_o.aux_btn  = {chord, 1'b0, btn_i[BI_L], btn_i[BI_R],
                       btn_i[BI_CUP], btn_i[BI_CDOWN],
                       btn_i[BI_CLEFT], btn_i[BI_CRIGHT]};
    word_o.axis_x   = lim[0];
    word_o.axis_y   = lim[1];
  end
endmodule

// File: rtl/pad_resp_seq.sv
module pad_resp_seq
  import pad_poll_pkg::*;
#(
  parameter byte_t ID_BYTE0 = 8'h05,
  parameter byte_t ID_BYTE1 = 8'h00,
  parameter byte_t ID_BYTE2 = 8'h01
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_valid_i,
  input  byte_t     cmd_byte_i,
  input  pad_word_t word_i,
  output logic      cmd_ready_o,
  output logic      rsp_valid_o,
  output byte_t     rsp_byte_o,
  output logic      rsp_last_o,
  input  logic      rsp_ready_i,
  output logic      err_o
);
  localparam int CNT_W = $clog2(WORD_BYTES + 1);

  typedef enum logic {S_IDLE, S_SEND} seq_state_e;

  seq_state_e       state;
  byte_t            pipe     [WORD_BYTES];
  byte_t            load_buf [WORD_BYTES];
  logic [CNT_W-1:0] load_len;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    load_len = '0;
    load_buf = '{default: '0};
    case (cmd_byte_i)
      CMD_IDENT: begin
        load_len    = CNT_W'(3);
        load_buf[0] = ID_BYTE0;
        load_buf[1] = ID_BYTE1;
        load_buf[2] = ID_BYTE2;
      end
      CMD_POLL: begin
        load_len    = CNT_W'(4);
        load_buf[0] = word_i.main_btn;
        load_buf[1] = word_i.aux_btn;
        load_buf[2] = word_i.axis_x;
        load_buf[3] = word_i.axis_y;
      end
      CMD_AUX_A, CMD_AUX_B: load_len = CNT_W'(1);
      default: load_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cnt         <= '0;
      rsp_valid_o <= 1'b0;
      rsp_last_o  <= 1'b0;
      err_o       <= 1'b0;
      for (int i = 0; i < WORD_BYTES; i++) pipe[i] <= '0;
    end else begin
      err_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid_i) begin
            if (load_len == '0) begin
              err_o <= 1'b1;
            end else begin
              state       <= S_SEND;
              pipe        <= load_buf;
              cnt         <= load_len;
              rsp_valid_o <= 1'b1;
              rsp_last_o  <= (load_len == CNT_W'(1));
            end
          end
        end
        S_SEND: begin
          if (rsp_ready_i) begin
            if (rsp_last_o) begin
              state       <= S_IDLE;
              rsp_valid_o <= 1'b0;
              rsp_last_o  <= 1'b0;
              cnt         <= '0;
            end else begin
              for (int i = 0; i < WORD_BYTES - 1; i++) pipe[i] <= pipe[i+1];
              pipe[WORD_BYTES-1] <= '0;
              cnt        <= cnt - CNT_W'(1);
              rsp_last_o <= (cnt == CNT_W'(2));
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state == S_IDLE);
  assign rsp_byte_o  = pipe[0];

  // R10: a stalled beat keeps its contents
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_byte_o) && $stable(rsp_last_o));
  // R11: no command is taken while a reply is in flight
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> !cmd_ready_o);
  // R8: unknown code gives an error pulse and no reply
  p_unknown_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_ready_o && cmd_valid_i && (cmd_byte_i > CMD_AUX_B) |=> err_o && !rsp_valid_o && cmd_ready_o);
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> cmd_ready_o && !rsp_valid_o);
  // R6: identify opens with its first fixed byte
  p_ident_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_ready_o && cmd_valid_i && (cmd_byte_i == CMD_IDENT) |=> rsp_valid_o && (rsp_byte_o == ID_BYTE0) && !rsp_last_o);
  // R7: auxiliary codes give one zero byte
  p_aux_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_ready_o && cmd_valid_i && ((cmd_byte_i == CMD_AUX_A) || (cmd_byte_i == CMD_AUX_B))
    |=> rsp_valid_o && rsp_last_o && (rsp_byte_o == 8'h00));
endmodule

// File: rtl/pad_poll_responder.sv
module pad_poll_responder
  import pad_poll_pkg::*;
#(
  parameter int    AXIS_LIMIT = 86,
  parameter byte_t ID_BYTE0   = 8'h05,
  parameter byte_t ID_BYTE1   = 8'h00,
  parameter byte_t ID_BYTE2   = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BTN_N-1:0]  btn_i,
  input  logic [BYTE_W-1:0] axis_x_i,
  input  logic [BYTE_W-1:0] axis_y_i,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  output logic              cmd_ready_o,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_byte_o,
  output logic              rsp_last_o,
  input  logic              rsp_ready_i,
  output logic              err_o
);
  localparam logic signed [BYTE_W-1:0] LIM_P = BYTE_W'(AXIS_LIMIT);
  localparam logic signed [BYTE_W-1:0] LIM_N = -LIM_P;

  pad_word_t live_word;

  pad_status_pack #(.AXIS_LIMIT(AXIS_LIMIT)) u_pack (
    .btn_i   (btn_i),
    .axis_x_i(axis_x_i),
    .axis_y_i(axis_y_i),
    .word_o  (live_word)
  );

  pad_resp_seq #(
    .ID_BYTE0(ID_BYTE0),
    .ID_BYTE1(ID_BYTE1),
    .ID_BYTE2(ID_BYTE2)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid_i(cmd_valid_i),
    .cmd_byte_i (cmd_byte_i),
    .word_i     (live_word),
    .cmd_ready_o(cmd_ready_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_byte_o (rsp_byte_o),
    .rsp_last_o (rsp_last_o),
    .rsp_ready_i(rsp_ready_i),
    .err_o      (err_o)
  );

  // R4: packed axes never leave the allowed window
  p_axis_range_r4: assert property (@(posedge clk) disable iff (rst)
    !($signed(live_word.axis_x) > LIM_P) && !($signed(live_word.axis_x) < LIM_N) &&
    !($signed(live_word.axis_y) > LIM_P) && !($signed(live_word.axis_y) < LIM_N));
  // R3: the chord masks Start and the stick
  p_chord_r3: assert property (@(posedge clk) disable iff (rst)
    btn_i[BI_L] && btn_i[BI_R] && btn_i[BI_START]
    |-> live_word.aux_btn[7] && !live_word.main_btn[4] &&
        (live_word.axis_x == '0) && (live_word.axis_y == '0));
endmodule

// File: tb/pad_poll_responder_bench.sv
`timescale 1ns/1ps
module pad_poll_responder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] btn = '0;
  logic [7:0]  ax = '0, ay = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        rsp_ready = 1'b1;
  logic        cmd_ready, rsp_valid, rsp_last, err;
  logic [7:0]  rsp_byte;

  int unsigned n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_req = "R11";

  // behavioural model state
  logic [7:0] q[$];
  bit m_ready = 1'b1;
  bit m_err = 1'b0;

  always #2 clk = ~clk;

  pad_poll_responder u_pad_poll_responder (
    .clk(clk), .rst(rst), .btn_i(btn), .axis_x_i(ax), .axis_y_i(ay),
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte), .cmd_ready_o(cmd_ready),
    .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte), .rsp_last_o(rsp_last),
    .rsp_ready_i(rsp_ready), .err_o(err)
  );

  function automatic logic [7:0] lim(input logic [7:0] v, input bit kill);
    int s = $signed(v);
    if (kill) return 8'h00;
    if (s > 86) s = 86;
    if (s < -86) s = -86;
    return 8'(s);
  endfunction

  task automatic push_reply(input logic [7:0] c);
    bit chord = btn[13] && btn[12] && btn[4];
    case (c)
      8'h00: begin q.push_back(8'h05); q.push_back(8'h00); q.push_back(8'h01); end
      8'h01: begin
        q.push_back({btn[7], btn[6], btn[5], btn[4] && !chord, btn[3], btn[2], btn[1], btn[0]});
        q.push_back({chord, 1'b0, btn[13], btn[12], btn[11], btn[10], btn[9], btn[8]});
        q.push_back(lim(ax, chord));
        q.push_back(lim(ay, chord));
      end
      8'h02, 8'h03: q.push_back(8'h00);
      default: ;
    endcase
  endtask

  task automatic compare();
    bit ev = (q.size() > 0);
    logic [7:0] eb = ev ? q[0] : 8'h00;
    bit el = (q.size() == 1);
    bit bad;
    n_cmp++;
    bad = (cmd_ready !== m_ready) || (rsp_valid !== ev) || (err !== m_err);
    if (ev && ((rsp_byte !== eb) || (rsp_last !== el))) bad = 1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s cycle %0d: rdy/val/err/byte/last got %b/%b/%b/%02h/%b expected %b/%b/%b/%02h/%b",
               cur_req, cycles, cmd_ready, rsp_valid, err, rsp_byte, rsp_last,
               m_ready, ev, m_err, eb, el);
    end
  endtask

  task automatic tick();
    bit nerr = 1'b0;
    if (rst) begin
      q.delete();
      m_ready = 1'b1;
    end else if (m_ready) begin
      if (cmd_valid) begin
        push_reply(cmd_byte);
        if (q.size() == 0) nerr = 1'b1;
        else m_ready = 1'b0;
      end
    end else if (rsp_ready) begin
      void'(q.pop_front());
      if (q.size() == 0) m_ready = 1'b1;
    end
    m_err = nerr;
    @(posedge clk);
    @(negedge clk);
    cycles++;
    compare();
  endtask

  // stall: 0 = always ready, 1 = random backpressure; noise: offer commands while busy
  task automatic run_cmd(input logic [7:0] c, input bit stall, input bit noise);
    cmd_valid = 1'b1;
    cmd_byte  = c;
    rsp_ready = stall ? 1'($urandom) : 1'b1;
    tick();
    cmd_valid = 1'b0;
    for (int g = 0; g < 64 && !m_ready; g++) begin
      rsp_ready = stall ? 1'($urandom) : 1'b1;
      if (noise) begin
        cmd_valid = 1'($urandom);
        cmd_byte  = 8'($urandom % 5);
      end
      tick();
    end
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    tick();
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL R11 watchdog: cycles got %0d expected below %0d", cycles, 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R11 reset state
    cur_req = "R11";
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 first byte: each button of the first group alone
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin
      btn = 14'(1) << i;
      run_cmd(8'h01, 1'b0, 1'b0);
    end
    // R2 second byte: each button of the second group alone
    cur_req = "R2";
    for (int i = 8; i < 14; i++) begin
      btn = 14'(1) << i;
      run_cmd(8'h01, 1'b0, 1'b0);
    end
    // R3 chord on and off
    cur_req = "R3";
    btn = 14'h3090; ax = 8'd50; ay = 8'hE2;
    run_cmd(8'h01, 1'b0, 1'b0);
    btn = 14'h3080;
    run_cmd(8'h01, 1'b0, 1'b0);
    btn = 14'h2010;
    run_cmd(8'h01, 1'b0, 1'b0);
    // R4 clamp boundaries
    cur_req = "R4";
    btn = '0;
    ax = 8'h7F; ay = 8'h80; run_cmd(8'h01, 1'b0, 1'b0);
    ax = 8'd86; ay = 8'hAA; run_cmd(8'h01, 1'b0, 1'b0);
    ax = 8'd87; ay = 8'hA9; run_cmd(8'h01, 1'b0, 1'b0);
    ax = 8'd0;  ay = 8'd5;  run_cmd(8'h01, 1'b0, 1'b0);
    // R5 mixed pattern
    cur_req = "R5";
    btn = 14'h2A5C; ax = 8'hF0; ay = 8'd33;
    run_cmd(8'h01, 1'b0, 1'b0);
    // R6 identify
    cur_req = "R6";
    run_cmd(8'h00, 1'b0, 1'b0);
    // R7 auxiliary codes
    cur_req = "R7";
    run_cmd(8'h02, 1'b0, 1'b0);
    run_cmd(8'h03, 1'b0, 1'b0);
    // R8 unknown codes
    cur_req = "R8";
    run_cmd(8'h04, 1'b0, 1'b0);
    run_cmd(8'h80, 1'b0, 1'b0);
    run_cmd(8'hFF, 1'b0, 1'b0);
    // R9 inputs change while the reply is stalled
    cur_req = "R9";
    btn = 14'h00F1; ax = 8'd20; ay = 8'hEC;
    cmd_valid = 1'b1; cmd_byte = 8'h01; rsp_ready = 1'b0;
    tick();
    cmd_valid = 1'b0;
    btn = 14'h3F0E; ax = 8'h81; ay = 8'd100;
    repeat (3) tick();
    rsp_ready = 1'b1;
    for (int g = 0; g < 8 && !m_ready; g++) tick();
    tick();
    // R10 random backpressure
    cur_req = "R10";
    btn = 14'h1555; ax = 8'hC0; ay = 8'd7;
    for (int k = 0; k < 6; k++) run_cmd(8'(k % 4), 1'b1, 1'b0);
    // R11 commands offered while busy are ignored
    cur_req = "R11";
    for (int k = 0; k < 10; k++) run_cmd(8'h01, 1'b1, 1'b1);
    // mixed random traffic
    cur_req = "R5";
    for (int k = 0; k < 300; k++) begin
      btn = 14'($urandom);
      ax  = 8'($urandom);
      ay  = 8'($urandom);
      run_cmd(((k % 7) == 6) ? 8'($urandom) : 8'($urandom % 4), 1'($urandom), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule